// File: doc/BRIEF.md
# SPI Register Slave with Software Reset

This block is the serial front end of a register-mapped peripheral core. An external master selects it by pulling the active-low chip enable low. The master then clocks in an 8-bit header that gives the access direction and a register address, followed by one 16-bit data word. SCLK idles low. Both sides capture data on the rising SCLK edge, and every field travels most significant bit first. Chip enable stays low for the whole transaction. The bit counter restarts only when chip enable goes high.

Behind the serial front end sit a small set of configuration registers and a small data RAM. A write header that names address 0 is not a register write. It raises a core-wide software reset as soon as the last header bit arrives. That reset holds until chip enable returns high. It puts every register back to its default value and leaves the RAM as it was. The external reset pin clears both the registers and the RAM.

SCLK, MOSI and chip enable pass through synchronizers into a system clock that runs at least four times faster than SCLK. The frame state machine has six states:

- IDLE: waits for chip enable.
- HDR: collects the header.
- WDATA: collects write data.
- RDATA: shifts read data out.
- SRST: holds the software reset.
- DONE: ignores the rest of the frame.

The transitions are named as follows:

- start: IDLE to HDR, when chip enable becomes active.
- hdr_write: HDR to WDATA.
- hdr_read: HDR to RDATA.
- hdr_reset: HDR to SRST.
- word_end: WDATA or RDATA to DONE, after the 16th data bit.
- release: any state to IDLE, when chip enable goes inactive.

Top module: `spi_regif_top`

## Requirements
- R1: Header bit 7 selects a read (1) or a write (0). Bit 6 is reserved. Bits 5:0 hold the address. Header and data are sampled on rising SCLK, MSB first.
- R2: A write header followed by 16 data bits updates the register at addresses 1 to 7. A later read of that address returns the word on MISO, MSB first, beginning with the bit that follows the header.
- R3: After reset, register n (1 to 7) reads 16'hA500 plus n.
- R4: Data RAM words at addresses 0x20 to 0x27 can be written and read back. The external reset pin clears them to zero.
- R5: A write header to address 0 raises core_rst once the 8th header bit has been sampled, and before the next SCLK rising edge. core_rst is low while the header is still incomplete.
- R6: core_rst stays high for as long as chip enable is low, and this includes any further SCLK activity. It falls within 6 system clocks after chip enable rises.
- R7: A software reset returns every register to its R3 default and leaves every RAM word unchanged.
- R8: A read of address 0 raises no reset, returns zero and changes no register.
- R9: The following accesses have no effect, and reads of them return zero: writes to unmapped addresses, and any access whose reserved header bit 6 is 1. A header with bit 6 set never causes a reset.
- R10: MISO is 0 while chip enable is inactive and during a write.
- R11: Data bits after the 16th in one frame are ignored until chip enable goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCLK rate |
| rst_n | input | 1 | External active-low reset pin |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data from the master |
| ce_n | input | 1 | Active-low chip enable |
| miso | output | 1 | Serial data to the master, 0 when not reading |
| core_rst | output | 1 | High while the core is held in reset (external or software) |

## Verification
The hardest case to reach is a software reset that is held across extra SCLK activity while chip enable stays low. The release then has to come from chip enable alone. The scenario for this sends a reset header and then keeps chip enable low while it clocks a further 16 bits. It probes core_rst at three points: just before the last header bit, during the hold, and after chip enable rises. It then reads back both registers and RAM through ordinary read frames. This proves that the defaults returned and the RAM was left intact.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

    localparam int WORD_W = 16;
    localparam int HDR_W  = 8;
    localparam int ADR_W  = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WDATA,
        ST_RDATA,
        ST_SRST,
        ST_DONE
    } frame_state_t;

    // Reset value of configuration register number idx.
    function automatic logic [WORD_W-1:0] reg_default(input int idx);
        return 16'hA500 | WORD_W'(idx);
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic sclk,
    input  logic mosi,
    input  logic ce_n,
    output logic sclk_rise,
    output logic mosi_s,
    output logic ce_act
);
    // One extra stage on SCLK gives the edge detector a delayed copy.
    logic [STAGES:0]   sclk_q;
    logic [STAGES-1:0] mosi_q;
    logic [STAGES-1:0] ce_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            sclk_q <= '0;
            mosi_q <= '0;
            ce_q   <= '1;
        end else begin
            sclk_q <= {sclk_q[STAGES-1:0], sclk};
            mosi_q <= {mosi_q[STAGES-2:0], mosi};
            ce_q   <= {ce_q[STAGES-2:0], ce_n};
        end
    end

    assign sclk_rise = sclk_q[STAGES-1] & ~sclk_q[STAGES];
    assign mosi_s    = mosi_q[STAGES-1];
    assign ce_act    = ~ce_q[STAGES-1];

endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_regif_pkg::*;
(
    input  logic              clk,
    input  logic              arst_n,
    input  logic              sclk_rise,
    input  logic              mosi_s,
    input  logic              ce_act,
    input  logic [WORD_W-1:0] rd_data,
    output logic [ADR_W-1:0]  acc_addr,
    output logic              acc_ok,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic              soft_rst,
    output logic              miso
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);

    frame_state_t      state, state_n;
    logic [CNT_W-1:0]  bitcnt, bitcnt_n;
    logic [HDR_W-2:0]  hdr, hdr_n;
    logic [WORD_W-1:0] sh, sh_n;
    logic [ADR_W-1:0]  addr_q, addr_n;
    logic              ok_q, ok_n;
    logic              wr_q, wr_n;
    logic [ADR_W-1:0]  hdr_addr;
    logic              hdr_rd, hdr_rsv;

    // Header fields as they stand once the current bit is appended.
    assign hdr_rd   = hdr[HDR_W-2];
    assign hdr_rsv  = hdr[HDR_W-3];
    assign hdr_addr = {hdr[ADR_W-2:0], mosi_s};

    // State register.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            hdr    <= '0;
            sh     <= '0;
            addr_q <= '0;
            ok_q   <= 1'b0;
            wr_q   <= 1'b0;
        end else begin
            state  <= state_n;
            bitcnt <= bitcnt_n;
            hdr    <= hdr_n;
            sh     <= sh_n;
            addr_q <= addr_n;
            ok_q   <= ok_n;
            wr_q   <= wr_n;
        end
    end

    // Transitions.
    always_comb begin
        state_n  = state;
        bitcnt_n = bitcnt;
        hdr_n    = hdr;
        sh_n     = sh;
        addr_n   = addr_q;
        ok_n     = ok_q;
        wr_n     = 1'b0;
        if (!ce_act) begin
            // release
            state_n  = ST_IDLE;
            bitcnt_n = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    // start
                    state_n  = ST_HDR;
                    bitcnt_n = '0;
                    hdr_n    = '0;
                end
                ST_HDR: begin
                    if (sclk_rise) begin
                        hdr_n    = {hdr[HDR_W-3:0], mosi_s};
                        bitcnt_n = bitcnt + 1'b1;
                        if (bitcnt == HDR_LAST) begin
                            bitcnt_n = '0;
                            addr_n   = hdr_addr;
                            ok_n     = ~hdr_rsv;
                            if (hdr_rd) begin
                                state_n = ST_RDATA;     // hdr_read
                                sh_n    = rd_data;
                            end else if (!hdr_rsv && hdr_addr == '0) begin
                                state_n = ST_SRST;      // hdr_reset
                            end else begin
                                state_n = ST_WDATA;     // hdr_write
                            end
                        end
                    end
                end
                ST_WDATA: begin
                    if (sclk_rise) begin
                        sh_n     = {sh[WORD_W-2:0], mosi_s};
                        bitcnt_n = bitcnt + 1'b1;
                        if (bitcnt == WORD_LAST) begin
                            wr_n    = ok_q;
                            state_n = ST_DONE;          // word_end
                        end
                    end
                end
                ST_RDATA: begin
                    if (sclk_rise) begin
                        sh_n     = {sh[WORD_W-2:0], 1'b0};
                        bitcnt_n = bitcnt + 1'b1;
                        if (bitcnt == WORD_LAST) begin
                            state_n = ST_DONE;          // word_end
                        end
                    end
                end
                ST_SRST: state_n = ST_SRST;
                ST_DONE: state_n = ST_DONE;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        soft_rst = (state == ST_SRST);
        miso     = (state == ST_RDATA) & sh[WORD_W-1];
        wr_en    = wr_q;
        wr_data  = sh;
        acc_addr = (state == ST_HDR) ? hdr_addr : addr_q;
        acc_ok   = (state == ST_HDR) ? ~hdr_rsv : ok_q;
    end

    // R5: reset only follows a completed write header
    assert_srst_cause_R5: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(soft_rst) |-> $past(state == ST_HDR && sclk_rise && !hdr_rd));
    assert_srst_hold_R6: assert property (@(posedge clk) disable iff (!arst_n)
        soft_rst && ce_act |=> soft_rst);
    assert_srst_release_R6: assert property (@(posedge clk) disable iff (!arst_n)
        soft_rst && !ce_act |=> !soft_rst);
    assert_miso_quiet_R10: assert property (@(posedge clk) disable iff (!arst_n)
        !ce_act |=> !miso);
    assert_wr_single_R2: assert property (@(posedge clk) disable iff (!arst_n)
        wr_en |=> !wr_en);

endmodule

// File: rtl/spi_reg_store.sv
module spi_reg_store
    import spi_regif_pkg::*;
#(
    parameter int             NREG      = 7,
    parameter int             RAM_DEPTH = 8,
    parameter logic [ADR_W-1:0] RAM_BASE = 6'h20
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              soft_rst,
    input  logic [ADR_W-1:0]  acc_addr,
    input  logic              acc_ok,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0]                 regs [NREG];
    logic [RAM_DEPTH-1:0][WORD_W-1:0]  ram;

    // Configuration registers: both resets restore defaults.
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                regs[i] <= reg_default(i + 1);
            end else if (soft_rst) begin
                regs[i] <= reg_default(i + 1);
            end else if (wr_en && acc_ok && acc_addr == ADR_W'(i + 1)) begin
                regs[i] <= wr_data;
            end
        end
    end

    // Data RAM: only the external pin clears it.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            ram <= '0;
        end else if (wr_en && acc_ok) begin
            for (int j = 0; j < RAM_DEPTH; j++) begin
                if (acc_addr == RAM_BASE + ADR_W'(j)) ram[j] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (acc_ok) begin
            for (int i = 0; i < NREG; i++) begin
                if (acc_addr == ADR_W'(i + 1)) rd_data = regs[i];
            end
            for (int j = 0; j < RAM_DEPTH; j++) begin
                if (acc_addr == RAM_BASE + ADR_W'(j)) rd_data = ram[j];
            end
        end
    end

    assert_ram_keep_R7: assert property (@(posedge clk) disable iff (!arst_n)
        soft_rst |=> $stable(ram));
    assert_rsv_nowrite_R9: assert property (@(posedge clk) disable iff (!arst_n)
        wr_en && !acc_ok |=> $stable(ram));

endmodule

// File: rtl/spi_regif_top.sv
module spi_regif_top
    import spi_regif_pkg::*;
#(
    parameter int             NREG      = 7,
    parameter int             RAM_DEPTH = 8,
    parameter logic [ADR_W-1:0] RAM_BASE = 6'h20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic mosi,
    input  logic ce_n,
    output logic miso,
    output logic core_rst
);
    logic [1:0]        rst_q;
    logic              arst_n;
    logic              sclk_rise, mosi_s, ce_act;
    logic [ADR_W-1:0]  acc_addr;
    logic              acc_ok, wr_en, soft_rst;
    logic [WORD_W-1:0] wr_data, rd_data;

    // Asynchronous assertion, synchronous release of the pin reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_q <= '0;
        else        rst_q <= {rst_q[0], 1'b1};
    end
    assign arst_n = rst_q[1];

    spi_in_sync #(.STAGES(2)) u_sync (
        .clk(clk), .arst_n(arst_n), .sclk(sclk), .mosi(mosi), .ce_n(ce_n),
        .sclk_rise(sclk_rise), .mosi_s(mosi_s), .ce_act(ce_act)
    );

    spi_frame_fsm u_fsm (
        .clk(clk), .arst_n(arst_n), .sclk_rise(sclk_rise), .mosi_s(mosi_s),
        .ce_act(ce_act), .rd_data(rd_data), .acc_addr(acc_addr),
        .acc_ok(acc_ok), .wr_en(wr_en), .wr_data(wr_data),
        .soft_rst(soft_rst), .miso(miso)
    );

    spi_reg_store #(.NREG(NREG), .RAM_DEPTH(RAM_DEPTH), .RAM_BASE(RAM_BASE)) u_store (
        .clk(clk), .arst_n(arst_n), .soft_rst(soft_rst), .acc_addr(acc_addr),
        .acc_ok(acc_ok), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    assign core_rst = ~arst_n | soft_rst;

    assert_miso_ce_R10: assert property (@(posedge clk) disable iff (!arst_n)
        ce_n && $past(ce_n) && $past(ce_n, 2) && $past(ce_n, 3) |-> !miso);

endmodule

// File: tb/spi_regif_top_test.sv
`timescale 1ns/1ps
module spi_regif_top_test;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic ce_n = 1'b1;
    logic miso, core_rst;
    int   total = 0;
    int   bad = 0;
    bit   ended = 1'b0;

    always #2.5 clk = ~clk;

    spi_regif_top uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi),
        .ce_n(ce_n), .miso(miso), .core_rst(core_rst)
    );

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sbits(input logic [31:0] v, input int n, output logic [31:0] got);
        got = '0;
        for (int i = n - 1; i >= 0; i--) begin
            mosi = v[i];
            wclk(HALF);
            got = {got[30:0], miso};
            sclk = 1'b1;
            wclk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic sbegin();
        ce_n = 1'b0;
        wclk(HALF);
    endtask

    task automatic send();
        wclk(HALF);
        ce_n = 1'b1;
        mosi = 1'b0;
        wclk(12);
    endtask

    task automatic reg_wr(input logic [7:0] hdr, input logic [15:0] d, output logic [31:0] got);
        logic [31:0] g;
        sbegin();
        sbits({24'h0, hdr}, 8, g);
        sbits({16'h0, d}, 16, got);
        send();
    endtask

    task automatic reg_rd(input logic [7:0] hdr, output logic [15:0] d);
        logic [31:0] g;
        sbegin();
        sbits({24'h0, hdr}, 8, g);
        sbits(32'h0, 16, g);
        d = g[15:0];
        send();
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk({31'h0, core_rst}, 0, "R3 core_rst low after reset");
        chk({31'h0, miso}, 0, "R10 miso idle");
        reg_rd(8'h83, d); chk({16'h0, d}, 32'hA503, "R3 default reg3");
        reg_rd(8'h87, d); chk({16'h0, d}, 32'hA507, "R3 default reg7");
    endtask

    task automatic t_write_read();
        logic [31:0] g; logic [15:0] d;
        reg_wr(8'h05, 16'h1234, g);
        chk(g, 0, "R10 miso zero during write");
        reg_rd(8'h85, d); chk({16'h0, d}, 32'h1234, "R2 reg5 readback");
        reg_wr(8'h01, 16'h8001, g);
        reg_rd(8'h81, d); chk({16'h0, d}, 32'h8001, "R1 MSB first reg1");
    endtask

    task automatic t_ram();
        logic [31:0] g; logic [15:0] d;
        reg_wr(8'h21, 16'hBEEF, g);
        reg_wr(8'h27, 16'h0F0F, g);
        reg_rd(8'hA1, d); chk({16'h0, d}, 32'hBEEF, "R4 ram 0x21");
        reg_rd(8'hA7, d); chk({16'h0, d}, 32'h0F0F, "R4 ram 0x27");
    endtask

    task automatic t_read_zero();
        logic [31:0] g; logic [15:0] d;
        sbegin();
        sbits(32'h80, 8, g);
        wclk(4);
        chk({31'h0, core_rst}, 0, "R8 no reset on read of 0");
        sbits(32'h0, 16, g);
        chk(g, 0, "R8 read of 0 returns zero");
        send();
        reg_rd(8'h85, d); chk({16'h0, d}, 32'h1234, "R8 reg5 kept");
    endtask

    task automatic t_unmapped();
        logic [31:0] g; logic [15:0] d;
        reg_wr(8'h10, 16'hABCD, g);
        reg_rd(8'h90, d); chk({16'h0, d}, 0, "R9 unmapped reads zero");
        reg_wr(8'h45, 16'h7777, g);
        reg_rd(8'h85, d); chk({16'h0, d}, 32'h1234, "R9 reserved bit blocks write");
        sbegin();
        sbits(32'h40, 8, g);
        wclk(4);
        chk({31'h0, core_rst}, 0, "R9 reserved bit blocks reset");
        sbits(32'h0, 16, g);
        send();
    endtask

    task automatic t_extra();
        logic [31:0] g; logic [15:0] d;
        sbegin();
        sbits(32'h02, 8, g);
        sbits(32'hCAFEFF, 24, g);
        send();
        reg_rd(8'h82, d); chk({16'h0, d}, 32'hCAFE, "R11 extra bits ignored");
    endtask

    task automatic t_soft();
        logic [31:0] g; logic [15:0] d;
        sbegin();
        sbits(32'h0, 7, g);
        chk({31'h0, core_rst}, 0, "R5 no reset before header ends");
        sbits(32'h0, 1, g);
        chk({31'h0, core_rst}, 1, "R5 reset after header");
        wclk(40);
        chk({31'h0, core_rst}, 1, "R6 reset held");
        sbits(32'h5A5A, 16, g);
        chk({31'h0, core_rst}, 1, "R6 reset held over sclk");
        ce_n = 1'b1;
        wclk(6);
        chk({31'h0, core_rst}, 0, "R6 reset released");
        wclk(6);
        reg_rd(8'h85, d); chk({16'h0, d}, 32'hA505, "R7 reg5 default");
        reg_rd(8'h82, d); chk({16'h0, d}, 32'hA502, "R7 reg2 default");
        reg_rd(8'hA1, d); chk({16'h0, d}, 32'hBEEF, "R7 ram kept");
    endtask

    task automatic t_ext();
        logic [15:0] d;
        rst_n = 1'b0;
        wclk(4);
        chk({31'h0, core_rst}, 1, "R4 pin reset drives core_rst");
        rst_n = 1'b1;
        wclk(6);
        reg_rd(8'hA1, d); chk({16'h0, d}, 0, "R4 ram cleared by pin");
        reg_rd(8'h81, d); chk({16'h0, d}, 32'hA501, "R3 reg1 default after pin");
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(6);
        t_reset();
        t_write_read();
        t_ram();
        t_read_zero();
        t_unmapped();
        t_extra();
        t_soft();
        t_ext();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

endmodule